// File: doc/BRIEF.md
# Programmable Up/Down Counter Timer

A 16-bit event counter with a byte-wide control register, a 16-bit time-constant register and a 16-bit capture register. The counter advances once for each rising edge seen on an asynchronous count input. The count input is brought into the system clock domain first, and the counter only moves while the enable bit is set. Each step goes up or down by one, as the direction bit selects.

Software drives the block with plain write strobes. The control register holds a set of command bits that clear themselves: load, software trigger and capture. It also holds a status bit that a write of 1 clears and a write of 0 leaves alone, an interrupt enable, and a mode bit. The mode bit picks between reloading the time constant on every terminal count and stopping at the terminal count. A rising edge on the external trigger input acts exactly like the software trigger.

Top module: `updown_ctr_timer`

## Requirements
- R1: After a synchronous active-low reset, the control register, counter, capture register and time constant are all zero and `irq` is low.
- R2: The counter changes only through a load or trigger while control bit 0 (enable) is 0. Writing 1 to the enable bit while it is already 1 leaves the count undisturbed.
- R3: Each rising edge of `cnt_in` gives exactly one count step. The step takes effect on the third clock edge after the clock edge that first samples `cnt_in` high.
- R4: Control bit 6 sets the direction: 1 adds one and 0 subtracts one, modulo 2^16.
- R5: A step that lands on the terminal value (0x0000 counting down, 0xFFFF counting up) sets control bit 1 (end of count) on that same edge.
- R6: Writing 1 to bit 1 clears it and writing 0 leaves it unchanged. If a terminal event happens in the same cycle as the write, the set wins.
- R7: `irq` is a one-cycle pulse, raised together with the status bit, and only when control bit 2 (interrupt enable) is 1.
- R8: With control bit 7 at 1 (continuous), the terminal step loads the time constant instead of the terminal value, and the enable bit stays set.
- R9: With bit 7 at 0 (single cycle), the counter stays at the terminal value and the enable bit clears itself.
- R10: Setting bit 5 (load) copies the time constant into the counter one clock later. The bit then reads 0, and loading does not set the enable bit.
- R11: Setting bit 3 (capture) copies the current count into the capture register one clock later, and the bit then reads 0.
- R12: Setting bit 4 (software trigger) or a rising edge on `trig_in` reloads the counter from the time constant. Bit 4 clears itself.
- R13: A load or trigger takes priority over a count step that falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| tc_we | input | 1 | Time-constant write strobe |
| tc_wdata | input | 16 | Time-constant write data |
| cnt_in | input | 1 | Asynchronous count input, at most a quarter of the clock rate |
| trig_in | input | 1 | Asynchronous external trigger, rising-edge active |
| ctl_q | output | 8 | Control register read value |
| count_q | output | 16 | Current count |
| capture_q | output | 16 | Captured count |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The hardest case to reach from the ports is a count step that lands on the same clock edge as a load, a trigger, or a write-1-to-clear of the status bit. The count input only reaches the counter three edges after it is sampled, so the timing of a software write has to be worked out against that delay. One directed case lines up a load write with a pending count step. A long random phase then toggles the count and trigger inputs densely, with frequent control and time-constant writes, so these collisions occur many times. A behavioural reference model checks every clock cycle.

// File: rtl/ctimer_pkg.sv
// Shared constants for the up/down counter timer: control-register width
// and the bit positions that the control logic and the counter core decode.
package ctimer_pkg;
    localparam int CTL_W   = 8;
    localparam int CB_EN   = 0;  // counting enable
    localparam int CB_EOC  = 1;  // end-of-count status, write 1 to clear
    localparam int CB_IEN  = 2;  // interrupt enable
    localparam int CB_CAP  = 3;  // capture command, self-clearing
    localparam int CB_TRG  = 4;  // software trigger, self-clearing
    localparam int CB_LD   = 5;  // load command, self-clearing
    localparam int CB_DIR  = 6;  // 1 = up, 0 = down
    localparam int CB_CONT = 7;  // 1 = reload at terminal, 0 = stop
endpackage

// File: rtl/ctimer_edge_sync.sv
// Synchronizes an asynchronous level into the clock domain and produces a
// registered one-cycle pulse for each rising edge.
// Assumes the input stays high and low for at least two clocks each.
module ctimer_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sync_q;
    logic          last_q;
    logic          pulse_q;

    // Synchronizer chain, previous-level flop and edge pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= '0;
            last_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            sync_q  <= {sync_q[LAST-1:0], async_in};
            last_q  <= sync_q[LAST];
            pulse_q <= sync_q[LAST] & ~last_q;
        end
    end

    assign rise_pulse = pulse_q;

    // A rising edge never produces a pulse two cycles long.
    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/ctimer_ctl_reg.sv
// Control register: software write strobe, self-clearing command bits,
// write-1-to-clear end-of-count status, and the enable bit that clears
// itself after a single-cycle run. Assumes term_evt is at most one cycle wide.
module ctimer_ctl_reg
    import ctimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    input  logic             term_evt,
    output logic [CTL_W-1:0] ctl_q
);
    logic [CTL_W-1:0] ctl_d;

    // Next-state: a write replaces the fields, otherwise commands drop.
    always_comb begin
        ctl_d = ctl_q;
        if (we) begin
            ctl_d         = wdata;
            ctl_d[CB_EOC] = term_evt | (ctl_q[CB_EOC] & ~wdata[CB_EOC]);
        end else begin
            ctl_d[CB_CAP] = 1'b0;
            ctl_d[CB_TRG] = 1'b0;
            ctl_d[CB_LD]  = 1'b0;
            if (term_evt) begin
                ctl_d[CB_EOC] = 1'b1;
                if (!ctl_q[CB_CONT]) ctl_d[CB_EN] = 1'b0;
            end
        end
    end

    // Register with all bits forced to zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assert_load_selfclear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[CB_LD] && !we) |=> !ctl_q[CB_LD]);
    assert_cap_selfclear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[CB_CAP] && !we) |=> !ctl_q[CB_CAP]);
    assert_trig_selfclear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[CB_TRG] && !we) |=> !ctl_q[CB_TRG]);
    assert_w1c_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[CB_EOC] && !term_evt) |=> !ctl_q[CB_EOC]);
    assert_status_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        term_evt |=> ctl_q[CB_EOC]);
    assert_single_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (term_evt && !ctl_q[CB_CONT] && !we) |=> !ctl_q[CB_EN]);
endmodule

// File: rtl/ctimer_core.sv
// Counter datapath: time-constant and capture registers, up/down step,
// terminal detection with optional reload, and the interrupt pulse.
// Assumes step pulses are never in back-to-back cycles.
module ctimer_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         up,
    input  logic         cont,
    input  logic         ien,
    input  logic         reload_req,
    input  logic         cap_req,
    input  logic         step,
    input  logic         tc_we,
    input  logic [W-1:0] tc_wdata,
    output logic [W-1:0] count_q,
    output logic [W-1:0] capture_q,
    output logic         term_evt,
    output logic         irq
);
    localparam logic [W-1:0] TERM_UP   = {W{1'b1}};
    localparam logic [W-1:0] TERM_DOWN = {W{1'b0}};

    logic [W-1:0] tc_q;
    logic [W-1:0] step_val;
    logic [W-1:0] term_val;
    logic         irq_q;

    // Candidate next value and the terminal value for this direction.
    always_comb begin
        step_val = up ? count_q + 1'b1 : count_q - 1'b1;
        term_val = up ? TERM_UP : TERM_DOWN;
        term_evt = !reload_req && en && step && (step_val == term_val);
    end

    // Time-constant register written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)     tc_q <= '0;
        else if (tc_we) tc_q <= tc_wdata;
    end

    // Counter: reload has priority, then an enabled step.
    always_ff @(posedge clk) begin
        if (!rst_n)             count_q <= '0;
        else if (reload_req)    count_q <= tc_q;
        else if (en && step)    count_q <= term_evt ? (cont ? tc_q : term_val) : step_val;
    end

    // Capture register sampled on the capture command.
    always_ff @(posedge clk) begin
        if (!rst_n)       capture_q <= '0;
        else if (cap_req) capture_q <= count_q;
    end

    // Interrupt pulse on a terminal event when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= term_evt & ien;
    end

    assign irq = irq_q;

    assert_hold_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !reload_req) |=> $stable(count_q));
    assert_capture_value_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cap_req |=> (capture_q == $past(count_q)));
    assert_reload_value_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_req && !tc_we) |=> (count_q == tc_q));
    assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

// File: rtl/updown_ctr_timer.sv
// Top of the up/down counter timer: two edge synchronizers (count and
// trigger), the control register and the counter core.
// Assumes cnt_in and trig_in change no faster than a quarter of clk.
module updown_ctr_timer
    import ctimer_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             tc_we,
    input  logic [W-1:0]     tc_wdata,
    input  logic             cnt_in,
    input  logic             trig_in,
    output logic [CTL_W-1:0] ctl_q,
    output logic [W-1:0]     count_q,
    output logic [W-1:0]     capture_q,
    output logic             irq
);
    logic cnt_pulse;
    logic trig_pulse;
    logic term_evt;
    logic reload_req;

    ctimer_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cnt_in), .rise_pulse(cnt_pulse));

    ctimer_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
        .clk(clk), .rst_n(rst_n), .async_in(trig_in), .rise_pulse(trig_pulse));

    ctimer_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
        .term_evt(term_evt), .ctl_q(ctl_q));

    // Load command, software trigger and hardware trigger share one reload.
    assign reload_req = ctl_q[CB_LD] | ctl_q[CB_TRG] | trig_pulse;

    ctimer_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .en(ctl_q[CB_EN]), .up(ctl_q[CB_DIR]), .cont(ctl_q[CB_CONT]),
        .ien(ctl_q[CB_IEN]), .reload_req(reload_req), .cap_req(ctl_q[CB_CAP]),
        .step(cnt_pulse), .tc_we(tc_we), .tc_wdata(tc_wdata),
        .count_q(count_q), .capture_q(capture_q),
        .term_evt(term_evt), .irq(irq));

    assert_irq_with_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctl_q[CB_EOC]);
    assert_irq_needs_ien_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ctl_q[CB_IEN]));
endmodule

// File: tb/tb_updown_ctr_timer.sv
module tb_updown_ctr_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic        tc_we = 1'b0;
    logic [15:0] tc_wdata = '0;
    logic        cnt_in = 1'b0;
    logic        trig_in = 1'b0;
    logic [7:0]  ctl_q;
    logic [15:0] count_q;
    logic [15:0] capture_q;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    int irq_seen = 0;
    string phase = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    updown_ctr_timer dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .tc_we(tc_we), .tc_wdata(tc_wdata), .cnt_in(cnt_in), .trig_in(trig_in),
        .ctl_q(ctl_q), .count_q(count_q), .capture_q(capture_q), .irq(irq));

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_ctl;
    logic [15:0] m_cnt, m_cap, m_tc;
    logic        m_irq;
    bit          cq[$];
    bit          tq[$];
    logic        m_cp, m_tp;
    bit          model_live = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl = '0; m_cnt = '0; m_cap = '0; m_tc = '0; m_irq = 0;
            cq = '{0, 0, 0, 0}; tq = '{0, 0, 0, 0};
            m_cp = 0; m_tp = 0;
            model_live = 1;
        end else begin
            logic [7:0]  n_ctl;
            logic [15:0] n_cnt, nxt, term;
            logic        evt, reload;
            evt = 0;
            n_cnt = m_cnt;
            reload = m_ctl[5] | m_ctl[4] | m_tp;
            if (reload) n_cnt = m_tc;
            else if (m_ctl[0] && m_cp) begin
                nxt  = m_ctl[6] ? m_cnt + 16'd1 : m_cnt - 16'd1;
                term = m_ctl[6] ? 16'hFFFF : 16'h0000;
                if (nxt == term) begin
                    evt = 1;
                    n_cnt = m_ctl[7] ? m_tc : term;
                end else n_cnt = nxt;
            end
            if (m_ctl[3]) m_cap = m_cnt;
            if (ctl_we) begin
                n_ctl = ctl_wdata;
                n_ctl[1] = evt | (m_ctl[1] & ~ctl_wdata[1]);
            end else begin
                n_ctl = m_ctl & 8'hC7;
                if (evt) begin
                    n_ctl[1] = 1;
                    if (!m_ctl[7]) n_ctl[0] = 0;
                end
            end
            m_irq = evt & m_ctl[2];
            if (tc_we) m_tc = tc_wdata;
            m_ctl = n_ctl;
            m_cnt = n_cnt;
            cq.push_front(cnt_in);  void'(cq.pop_back());
            tq.push_front(trig_in); void'(tq.pop_back());
            m_cp = cq[2] & ~cq[3];
            m_tp = tq[2] & ~tq[3];
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (irq) irq_seen++;
        if (rst_n && model_live) begin
            n_vec++;
            if (ctl_q !== m_ctl || count_q !== m_cnt || capture_q !== m_cap || irq !== m_irq) begin
                n_bad++;
                $display("FAIL %s model: ctl=%h/%h cnt=%h/%h cap=%h/%h irq=%b/%b (actual/expected)",
                         phase, ctl_q, m_ctl, count_q, m_cnt, capture_q, m_cap, irq, m_irq);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr_ctl(logic [7:0] d);
        ctl_we = 1; ctl_wdata = d; tick(1); ctl_we = 0;
    endtask

    task automatic wr_tc(logic [15:0] d);
        tc_we = 1; tc_wdata = d; tick(1); tc_we = 0;
    endtask

    task automatic pulse_cnt();
        cnt_in = 1; tick(2); cnt_in = 0; tick(2);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int irq_before;
        logic [15:0] snap;
        tick(3);
        // R1 reset state
        chk("R1 ctl", ctl_q, 0);
        chk("R1 count", count_q, 0);
        chk("R1 capture", capture_q, 0);
        chk("R1 irq", irq, 0);
        rst_n = 1;
        tick(2);

        // R10 load without start
        phase = "R10";
        wr_tc(16'd5);
        wr_ctl(8'h20);
        tick(1);
        chk("R10 count", count_q, 5);
        chk("R10 ctl", ctl_q, 8'h00);

        // R2 disabled counter ignores count edges
        phase = "R2";
        pulse_cnt();
        tick(2);
        chk("R2 hold", count_q, 5);

        // R3 R4 R5 R7 R9 single-cycle down with interrupt
        phase = "R9";
        wr_ctl(8'h05);
        irq_before = irq_seen;
        repeat (4) pulse_cnt();
        chk("R4 down step", count_q, 1);
        chk("R3 one step per edge", ctl_q, 8'h05);
        pulse_cnt();
        chk("R5 count zero", count_q, 0);
        chk("R9 enable cleared", ctl_q, 8'h06);
        tick(1);
        chk("R7 one irq", irq_seen - irq_before, 1);
        pulse_cnt();
        chk("R9 stays at terminal", count_q, 0);

        // R6 write-1-to-clear
        phase = "R6";
        wr_ctl(8'h04);
        chk("R6 write 0 keeps", ctl_q, 8'h06);
        wr_ctl(8'h06);
        chk("R6 write 1 clears", ctl_q, 8'h04);

        // R8 continuous up without interrupt
        phase = "R8";
        wr_tc(16'hFFFC);
        wr_ctl(8'h20);
        tick(1);
        wr_ctl(8'hC1);
        irq_before = irq_seen;
        pulse_cnt();
        chk("R4 up step", count_q, 16'hFFFD);
        pulse_cnt(); pulse_cnt();
        chk("R8 reload", count_q, 16'hFFFC);
        chk("R8 enable kept", ctl_q, 8'hC3);
        chk("R7 no irq when disabled", irq_seen - irq_before, 0);

        // R2 rewriting enable while set
        wr_ctl(8'hC1);
        chk("R2 rewrite enable", count_q, 16'hFFFC);
        pulse_cnt();
        chk("R2 still counting", count_q, 16'hFFFD);

        // R11 capture
        phase = "R11";
        snap = count_q;
        wr_ctl(8'hC9);
        tick(1);
        chk("R11 capture", capture_q, snap);
        chk("R11 selfclear", ctl_q[3], 0);

        // R12 software and external trigger
        phase = "R12";
        wr_ctl(8'hD1);
        tick(1);
        chk("R12 sw trigger", count_q, 16'hFFFC);
        chk("R12 selfclear", ctl_q[4], 0);
        pulse_cnt();
        trig_in = 1; tick(2); trig_in = 0; tick(3);
        chk("R12 ext trigger", count_q, 16'hFFFC);

        // R13 load colliding with a pending step
        phase = "R13";
        wr_tc(16'h0100);
        cnt_in = 1; tick(2);
        wr_ctl(8'hE1);
        cnt_in = 0;
        tick(3);
        chk("R13 reload wins", count_q, 16'h0100);

        // Random phase: collisions of steps, reloads and status writes (R13, R6, R3)
        phase = "R13 random";
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 3) == 0) cnt_in = ~cnt_in;
            if ($urandom_range(0, 15) == 0) trig_in = ~trig_in;
            ctl_we = ($urandom_range(0, 11) == 0);
            ctl_wdata = 8'($urandom_range(0, 255));
            tc_we = ($urandom_range(0, 31) == 0);
            tc_wdata = ($urandom_range(0, 1) == 1) ? 16'($urandom_range(0, 6)) :
                                                     16'(16'hFFF9 + $urandom_range(0, 6));
            tick(1);
        end
        ctl_we = 0; tc_we = 0;
        tick(4);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule